// File: doc/BRIEF.md
# Window Transfer and Dirty-Region Tracker

This block controls rectangular window writes into a pixel frame buffer. Software sets four 10-bit window corners. Each corner is written in two steps: an 8-bit low part and a 2-bit high part. When a transfer is armed, the block checks the window against the source selection and the pixel size. It then works out how many 16-bit words the window needs. Arriving data words are passed to the frame buffer, each tagged with the address of the pixel its first byte belongs to.

When the last word of a window is accepted, the window rectangle (end coordinates exclusive) is merged into a bounding box of screen area that has changed since the last refresh. The display refresh side reads the box and pulses `refresh_done` once it has consumed it. That pulse returns the box to an inverted empty state built from the current display size. Toggling display enable or blanking marks the whole screen as changed.

Data moves as a valid/ready stream from `dp_*` to `fb_*`. While a transfer runs, a word is taken only when the frame buffer side is ready, so `fb_ready` low holds back `dp_ready`. If no transfer is armed and the window is valid, the first data word is stalled for one cycle while the transfer is set up from it. If no transfer is armed and the window is invalid, data words are accepted and dropped. `dp_ready` is held low in any cycle that carries `src_wr`.

Top module: `win_xfer_tracker`

## Requirements
- R1: Corner writes use `coord_sel` 0 = x start, 1 = y start, 2 = x end, 3 = y end. With `coord_hi`=0 a write replaces bits 7:0 of the corner from `coord_val`. With `coord_hi`=1 it replaces bits 9:8 from `coord_val[1:0]` and ignores `coord_val[7:2]`. The other part of the corner keeps its value.
- R2: `win_ok` is low when `src_sel` > 3, when `pix_bytes` is not 2, 3 or 4, or when an end corner is below its start. A `src_wr` while `win_ok` is low ends any transfer and arms none. Data words that arrive with no transfer armed and `win_ok` low are accepted and dropped, with no frame buffer write and no change to the dirty box.
- R3: A transfer makes exactly floor(`pix_bytes` × (xe−xs+1) × (ye−ys+1) / 2) frame buffer writes. `xfer_busy` then falls.
- R4: A transfer is armed on `src_wr` with `win_ok` high, taking effect the next cycle. It is also armed when a data word is offered with no transfer armed and `win_ok` high; that word is stalled for exactly one cycle (`dp_ready` low, `xfer_busy` low), then carried.
- R5: Word k of a transfer carries `fb_addr` = y × W + x, where W is the display width. Pixel p = floor(2k / `pix_bytes`) sits at x = xs + p mod width and y = ys + floor(p / width). `fb_data` equals the accepted `dp_data`.
- R6: While a transfer runs, `dp_ready` is low whenever `fb_ready` is low. `fb_addr` holds while a write is offered and not taken.
- R7: Committing a window lowers `dirty_x0`/`dirty_y0` to xs/ys if they are smaller, and raises `dirty_x1`/`dirty_y1` to xe+1/ye+1 if they are larger. `dirty_any` is high when `dirty_x1` > `dirty_x0`.
- R8: One cycle after `refresh_done`, the box is `dirty_x0`=W, `dirty_x1`=0, `dirty_y0`=H, `dirty_y1`=0. A window committed in the same cycle is merged into this cleared box.
- R9: A change of `disp_en` or `disp_blank` sets the box to 0..W by 0..H one cycle later. This takes priority over refresh and commit.
- R10: A `src_wr` with `win_ok` high during a running transfer drops the words still owed, commits nothing for the old window, and starts the new one.
- R11: After reset no transfer runs, `dirty_x0` and `dirty_y0` are all ones, `dirty_x1` and `dirty_y1` are 0, and `dirty_any` is low.
- R12: The display width W is 8 × `disp_w8` pixels. The display height H is the 10-bit `disp_h`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coord_wr | input | 1 | Corner write strobe |
| coord_sel | input | 2 | Corner select |
| coord_hi | input | 1 | 1 = high part, 0 = low byte |
| coord_val | input | 8 | Corner write value |
| src_sel | input | 3 | Data source selection |
| src_wr | input | 1 | Arm or restart a transfer |
| pix_bytes | input | 3 | Bytes per pixel of the incoming format |
| disp_w8 | input | 7 | Display width in units of 8 pixels |
| disp_h | input | 10 | Display height in lines |
| disp_en | input | 1 | Display enable |
| disp_blank | input | 1 | Display blanking |
| refresh_done | input | 1 | Refresh side has consumed the box |
| dp_valid | input | 1 | Data word offered |
| dp_ready | output | 1 | Data word taken |
| dp_data | input | 16 | Data word |
| fb_valid | output | 1 | Frame buffer write offered |
| fb_ready | input | 1 | Frame buffer can take a write |
| fb_addr | output | 21 | Pixel address of the write |
| fb_data | output | 16 | Write data |
| win_ok | output | 1 | Current window and format are acceptable |
| xfer_busy | output | 1 | Transfer armed |
| dirty_x0 | output | 11 | Box left edge |
| dirty_x1 | output | 11 | Box right edge, exclusive |
| dirty_y0 | output | 11 | Box top edge |
| dirty_y1 | output | 11 | Box bottom edge, exclusive |
| dirty_any | output | 1 | Box is not empty |

## Verification
The properties assume a well-behaved stream source. A word offered while `fb_ready` is low is expected to be followed by no `src_wr` before it is taken, since only then must `fb_addr` hold. The properties also assume that the refresh pulse is the only thing that can leave the box with a nonzero left edge and a nonzero right edge together. The stimulus respects this. It raises `src_wr` only while `dp_valid` is low. It keeps `disp_en` and `disp_blank` steady around refresh pulses. It changes corners only while no word is in flight. A periodic back-pressure pattern on `fb_ready` forces stalled offers in the middle of windows whose pixels straddle word boundaries.

// File: rtl/win_pkg.sv
package win_pkg;
  typedef enum logic [1:0] {
    CRD_XS = 2'd0,
    CRD_YS = 2'd1,
    CRD_XE = 2'd2,
    CRD_YE = 2'd3
  } crd_idx_e;

  localparam int CRD_COUNT = 4;
  localparam int MIN_PIX_BYTES = 2;
  localparam int MAX_PIX_BYTES = 4;
  localparam int MAX_SOURCE = 3;
endpackage

// File: rtl/win_coord_regs.sv
module win_coord_regs #(
  parameter int CW = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [1:0]             sel,
  input  logic                   hi,
  input  logic [7:0]             val,
  output logic [win_pkg::CRD_COUNT-1:0][CW-1:0] coord
);
  localparam int HW = CW - 8;

  for (genvar i = 0; i < win_pkg::CRD_COUNT; i++) begin : g_crd
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        coord[i] <= '0;
      end else if (wr && sel == 2'(i)) begin
        if (hi) coord[i][CW-1:8] <= val[HW-1:0];
        else    coord[i][7:0]    <= val;
      end
    end
  end
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen #(
  parameter int CW = 10,
  parameter int AW = 21,
  parameter int NW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic          step,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] ld_pitch,
  input  logic [CW:0]   ld_w,
  input  logic [2:0]    ld_bpp,
  input  logic [NW-1:0] ld_words,
  output logic          busy,
  output logic          last,
  output logic [AW-1:0] addr
);
  logic [NW-1:0] left;
  logic [AW-1:0] pitch;
  logic [CW:0]   w, xoff;
  logic [2:0]    bpp, acc;
  logic [3:0]    acc_sum;
  logic          adv;

  // bytes of the current pixel already covered, plus the two of this word
  assign acc_sum = {1'b0, acc} + 4'd2;
  assign adv     = acc_sum >= {1'b0, bpp};
  assign last    = busy && (left == NW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      left  <= '0;
      addr  <= '0;
      pitch <= '0;
      w     <= '0;
      xoff  <= '0;
      bpp   <= '0;
      acc   <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      left  <= ld_words;
      addr  <= ld_addr;
      pitch <= ld_pitch;
      w     <= ld_w;
      bpp   <= ld_bpp;
      acc   <= '0;
      xoff  <= '0;
    end else if (clear) begin
      busy <= 1'b0;
    end else if (step) begin
      left <= left - NW'(1);
      if (last) busy <= 1'b0;
      acc <= adv ? 3'(acc_sum - {1'b0, bpp}) : acc_sum[2:0];
      if (adv) begin
        if (xoff == w - (CW+1)'(1)) begin
          xoff <= '0;
          addr <= addr + pitch - AW'(w) + AW'(1);
        end else begin
          xoff <= xoff + (CW+1)'(1);
          addr <= addr + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/win_dirty_box.sv
module win_dirty_box #(
  parameter int BW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          force_full,
  input  logic          merge,
  input  logic [BW-1:0] mx0,
  input  logic [BW-1:0] mx1,
  input  logic [BW-1:0] my0,
  input  logic [BW-1:0] my1,
  input  logic [BW-1:0] disp_w,
  input  logic [BW-1:0] disp_h,
  output logic [BW-1:0] x0,
  output logic [BW-1:0] x1,
  output logic [BW-1:0] y0,
  output logic [BW-1:0] y1,
  output logic          any
);
  logic [BW-1:0] bx0, bx1, by0, by1;

  // a refresh in the same cycle hands the old box over; merge into the cleared one
  always_comb begin
    bx0 = clear ? disp_w : x0;
    bx1 = clear ? '0     : x1;
    by0 = clear ? disp_h : y0;
    by1 = clear ? '0     : y1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x0 <= '1;
      x1 <= '0;
      y0 <= '1;
      y1 <= '0;
    end else if (force_full) begin
      x0 <= '0;
      x1 <= disp_w;
      y0 <= '0;
      y1 <= disp_h;
    end else if (merge) begin
      x0 <= (mx0 < bx0) ? mx0 : bx0;
      x1 <= (mx1 > bx1) ? mx1 : bx1;
      y0 <= (my0 < by0) ? my0 : by0;
      y1 <= (my1 > by1) ? my1 : by1;
    end else if (clear) begin
      x0 <= bx0;
      x1 <= bx1;
      y0 <= by0;
      y1 <= by1;
    end
  end

  assign any = x1 > x0;
endmodule

// File: rtl/win_xfer_tracker.sv
module win_xfer_tracker #(
  parameter int CW  = 10,
  parameter int W8W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coord_wr,
  input  logic [1:0]        coord_sel,
  input  logic              coord_hi,
  input  logic [7:0]        coord_val,
  input  logic [2:0]        src_sel,
  input  logic              src_wr,
  input  logic [2:0]        pix_bytes,
  input  logic [W8W-1:0]    disp_w8,
  input  logic [CW-1:0]     disp_h,
  input  logic              disp_en,
  input  logic              disp_blank,
  input  logic              refresh_done,
  input  logic              dp_valid,
  output logic              dp_ready,
  input  logic [15:0]       dp_data,
  output logic              fb_valid,
  input  logic              fb_ready,
  output logic [2*CW:0]     fb_addr,
  output logic [15:0]       fb_data,
  output logic              win_ok,
  output logic              xfer_busy,
  output logic [CW:0]       dirty_x0,
  output logic [CW:0]       dirty_x1,
  output logic [CW:0]       dirty_y0,
  output logic [CW:0]       dirty_y1,
  output logic              dirty_any
);
  import win_pkg::*;

  localparam int BW = CW + 1;
  localparam int AW = 2*CW + 1;
  localparam int NW = 2*CW + 2;
  localparam int PW = NW + 1;

  logic [CRD_COUNT-1:0][CW-1:0] crd;
  logic [CW-1:0] xs, ys, xe, ye;
  logic [BW-1:0] win_w, win_h, disp_wpix;
  logic [PW-1:0] byte_total;
  logic [AW-1:0] pitch, start_addr;
  logic          idle_setup, load, clear, step, last;
  logic          en_q, blank_q, force_full;
  logic [BW-1:0] cx0, cx1, cy0, cy1;

  win_coord_regs #(.CW(CW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (coord_wr),
    .sel   (coord_sel),
    .hi    (coord_hi),
    .val   (coord_val),
    .coord (crd)
  );

  assign xs = crd[CRD_XS];
  assign ys = crd[CRD_YS];
  assign xe = crd[CRD_XE];
  assign ye = crd[CRD_YE];

  assign win_ok = (src_sel <= 3'(MAX_SOURCE)) &&
                  (pix_bytes >= 3'(MIN_PIX_BYTES)) &&
                  (pix_bytes <= 3'(MAX_PIX_BYTES)) &&
                  (xe >= xs) && (ye >= ys);

  assign win_w      = BW'(xe) - BW'(xs) + BW'(1);
  assign win_h      = BW'(ye) - BW'(ys) + BW'(1);
  assign byte_total = PW'(pix_bytes) * PW'(win_w) * PW'(win_h);
  assign disp_wpix  = BW'({disp_w8, 3'b000});
  assign pitch      = AW'(disp_wpix);
  assign start_addr = AW'(ys) * pitch + AW'(xs);

  assign idle_setup = !xfer_busy && dp_valid && win_ok && !src_wr;
  assign load       = (src_wr && win_ok) || idle_setup;
  assign clear      = src_wr && !win_ok;

  assign fb_valid = xfer_busy && dp_valid && !src_wr;
  assign fb_data  = dp_data;
  assign dp_ready = src_wr ? 1'b0 : (xfer_busy ? fb_ready : !win_ok);
  assign step     = fb_valid && fb_ready;

  win_addr_gen #(.CW(CW), .AW(AW), .NW(NW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .clear    (clear),
    .step     (step),
    .ld_addr  (start_addr),
    .ld_pitch (pitch),
    .ld_w     (win_w),
    .ld_bpp   (pix_bytes),
    .ld_words (byte_total[PW-1:1]),
    .busy     (xfer_busy),
    .last     (last),
    .addr     (fb_addr)
  );

  // window snapshot taken when armed, used at commit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cx0 <= '0; cx1 <= '0; cy0 <= '0; cy1 <= '0;
      en_q <= 1'b0; blank_q <= 1'b0;
    end else begin
      en_q    <= disp_en;
      blank_q <= disp_blank;
      if (load) begin
        cx0 <= BW'(xs);
        cx1 <= BW'(xe) + BW'(1);
        cy0 <= BW'(ys);
        cy1 <= BW'(ye) + BW'(1);
      end
    end
  end

  assign force_full = (disp_en != en_q) || (disp_blank != blank_q);

  win_dirty_box #(.BW(BW)) u_box (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (refresh_done),
    .force_full (force_full),
    .merge      (step && last),
    .mx0        (cx0),
    .mx1        (cx1),
    .my0        (cy0),
    .my1        (cy1),
    .disp_w     (disp_wpix),
    .disp_h     (BW'(disp_h)),
    .x0         (dirty_x0),
    .x1         (dirty_x1),
    .y0         (dirty_y0),
    .y1         (dirty_y1),
    .any        (dirty_any)
  );
endmodule

// File: rtl/win_xfer_tracker_chk.sv
module win_xfer_tracker_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          src_wr,
  input logic          refresh_done,
  input logic          dp_valid,
  input logic          dp_ready,
  input logic          fb_valid,
  input logic          fb_ready,
  input logic [2*CW:0] fb_addr,
  input logic          win_ok,
  input logic          xfer_busy,
  input logic [CW:0]   dirty_x0,
  input logic [CW:0]   dirty_x1
);
  p_no_idle_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> xfer_busy);

  p_reject_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    src_wr && !win_ok |=> !xfer_busy);

  p_idle_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy && dp_valid && win_ok && !src_wr |=> xfer_busy);

  p_ready_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy && dp_ready |-> fb_ready);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid && !fb_ready && !src_wr |=> $stable(fb_addr));

  p_refresh_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_done && !xfer_busy |=> (dirty_x1 == '0) || (dirty_x0 == '0));
endmodule

bind win_xfer_tracker win_xfer_tracker_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_wr       (src_wr),
  .refresh_done (refresh_done),
  .dp_valid     (dp_valid),
  .dp_ready     (dp_ready),
  .fb_valid     (fb_valid),
  .fb_ready     (fb_ready),
  .fb_addr      (fb_addr),
  .win_ok       (win_ok),
  .xfer_busy    (xfer_busy),
  .dirty_x0     (dirty_x0),
  .dirty_x1     (dirty_x1)
);

// File: tb/win_xfer_tracker_test.sv
`timescale 1ns/1ps
module win_xfer_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        coord_wr = 0, coord_hi = 0, src_wr = 0;
  logic [1:0]  coord_sel = 0;
  logic [7:0]  coord_val = 0;
  logic [2:0]  src_sel = 0, pix_bytes = 0;
  logic [6:0]  disp_w8 = 0;
  logic [9:0]  disp_h = 0;
  logic        disp_en = 0, disp_blank = 0, refresh_done = 0;
  logic        dp_valid = 0, fb_ready = 1;
  logic [15:0] dp_data = 0;
  logic        dp_ready, fb_valid, win_ok, xfer_busy, dirty_any;
  logic [20:0] fb_addr;
  logic [15:0] fb_data;
  logic [10:0] dirty_x0, dirty_x1, dirty_y0, dirty_y1;

  int checks = 0, errors = 0;
  int q_addr[$];
  int q_data[$];
  int bx0 = 2047, bx1 = 0, by0 = 2047, by1 = 0;
  bit bp_mode = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  win_xfer_tracker uut (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // back-pressure pattern on the frame buffer side
  always @(posedge clk) begin
    #1;
    cyc++;
    fb_ready = bp_mode ? (cyc % 3 != 0) : 1'b1;
  end

  // monitor: pops the scoreboard on every accepted write
  always @(negedge clk) begin
    if (rst_n && xfer_busy && !fb_ready && dp_valid)
      chk(dp_ready == 1'b0, "R6", "dp_ready under back-pressure", int'(dp_ready), 0);
    if (rst_n && fb_valid && fb_ready) begin
      if (q_addr.size() == 0) begin
        chk(1'b0, "R2", "unexpected frame buffer write addr", int'(fb_addr), -1);
      end else begin
        int ea, ed;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        chk(int'(fb_addr) == ea, "R5", "fb_addr", int'(fb_addr), ea);
        chk(int'(fb_data) == ed, "R5", "fb_data", int'(fb_data), ed);
      end
    end
  end

  task automatic wr_coord(int sel, int v);
    coord_sel = 2'(sel);
    coord_wr  = 1;
    coord_hi  = 1;
    coord_val = {6'b101011, 2'(v >> 8)};   // junk in bits 7:2 must be ignored (R1)
    @(posedge clk); #1;
    coord_hi  = 0;
    coord_val = 8'(v);
    @(posedge clk); #1;
    coord_wr  = 0;
  endtask

  task automatic set_win(int xs, int ys, int xe, int ye);
    wr_coord(0, xs); wr_coord(1, ys); wr_coord(2, xe); wr_coord(3, ye);
  endtask

  task automatic strobe_src(int s);
    src_sel = 3'(s);
    src_wr  = 1;
    @(posedge clk); #1;
    src_wr  = 0;
  endtask

  function automatic int nwords(int xs, int ys, int xe, int ye, int b);
    return (b * (xe - xs + 1) * (ye - ys + 1)) / 2;
  endfunction

  task automatic push_exp(int xs, int ys, int xe, int ye, int b, int dw, int base);
    int w = xe - xs + 1;
    for (int k = 0; k < nwords(xs, ys, xe, ye, b); k++) begin
      int p = (2 * k) / b;
      q_addr.push_back((ys + p / w) * dw + xs + p % w);
      q_data.push_back((base + k) & 16'hffff);
    end
  endtask

  task automatic send_word(int d);
    dp_data  = 16'(d);
    dp_valid = 1;
    @(negedge clk);
    while (!dp_ready) @(negedge clk);
    @(posedge clk); #1;
    dp_valid = 0;
  endtask

  task automatic merge_box(int xs, int ys, int xe, int ye);
    if (xs < bx0) bx0 = xs;
    if (xe + 1 > bx1) bx1 = xe + 1;
    if (ys < by0) by0 = ys;
    if (ye + 1 > by1) by1 = ye + 1;
  endtask

  task automatic chk_box(string req);
    @(negedge clk);
    chk(int'(dirty_x0) == bx0, req, "dirty_x0", int'(dirty_x0), bx0);
    chk(int'(dirty_x1) == bx1, req, "dirty_x1", int'(dirty_x1), bx1);
    chk(int'(dirty_y0) == by0, req, "dirty_y0", int'(dirty_y0), by0);
    chk(int'(dirty_y1) == by1, req, "dirty_y1", int'(dirty_y1), by1);
    chk(dirty_any == (bx1 > bx0), req, "dirty_any", int'(dirty_any), int'(bx1 > bx0));
  endtask

  task automatic do_refresh(int dw, int dh);
    refresh_done = 1;
    @(posedge clk); #1;
    refresh_done = 0;
    bx0 = dw; bx1 = 0; by0 = dh; by1 = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset state
    @(negedge clk);
    chk(xfer_busy == 0, "R11", "xfer_busy", int'(xfer_busy), 0);
    chk_box("R11");

    // R1 R3 R5 R7 R12: 16-bit pixels, src_wr start, W=32
    disp_w8 = 7'd4; disp_h = 10'd20; pix_bytes = 3'd2;
    set_win(3, 2, 6, 3);
    @(negedge clk);
    chk(win_ok == 1, "R2", "win_ok valid window", int'(win_ok), 1);
    push_exp(3, 2, 6, 3, 2, 32, 16'h1000);
    strobe_src(0);
    n = nwords(3, 2, 6, 3, 2);
    for (int k = 0; k < n; k++) begin
      if (k == n - 1) chk(xfer_busy == 1, "R3", "busy before last word", int'(xfer_busy), 1);
      send_word(16'h1000 + k);
    end
    chk(xfer_busy == 0, "R3", "busy after last word", int'(xfer_busy), 0);
    chk(q_addr.size() == 0, "R3", "words left in scoreboard", q_addr.size(), 0);
    merge_box(3, 2, 6, 3);
    chk_box("R7");

    // R8 R12 refresh clears to display size
    do_refresh(32, 20);
    chk_box("R8");

    // R1 R4 R6: high parts, 3-byte pixels, started by the first data word
    disp_w8 = 7'd100; disp_h = 10'd600; pix_bytes = 3'd3;
    set_win(10'h104, 10'h102, 10'h107, 10'h103);
    wr_coord(0, 10'h104);    // high written again, low preserved
    bp_mode = 1;
    push_exp(10'h104, 10'h102, 10'h107, 10'h103, 3, 800, 16'h2000);
    dp_data = 16'h2000; dp_valid = 1;
    @(negedge clk);
    chk(dp_ready == 0, "R4", "first word stalled", int'(dp_ready), 0);
    chk(xfer_busy == 0, "R4", "busy during setup", int'(xfer_busy), 0);
    @(negedge clk);
    chk(xfer_busy == 1, "R4", "busy after setup", int'(xfer_busy), 1);
    while (!dp_ready) @(negedge clk);
    @(posedge clk); #1; dp_valid = 0;
    n = nwords(10'h104, 10'h102, 10'h107, 10'h103, 3);
    for (int k = 1; k < n; k++) send_word(16'h2000 + k);
    chk(xfer_busy == 0, "R3", "busy after 3-byte window", int'(xfer_busy), 0);
    chk(q_addr.size() == 0, "R5", "3-byte words left", q_addr.size(), 0);
    merge_box(10'h104, 10'h102, 10'h107, 10'h103);
    chk_box("R1");

    // R5 R7: 4-byte pixels, union with previous window
    pix_bytes = 3'd4;
    set_win(40, 7, 42, 7);
    push_exp(40, 7, 42, 7, 4, 800, 16'h3000);
    strobe_src(3);
    n = nwords(40, 7, 42, 7, 4);
    for (int k = 0; k < n; k++) send_word(16'h3000 + k);
    bp_mode = 0;
    merge_box(40, 7, 42, 7);
    chk_box("R7");

    // R2 rejections
    set_win(50, 5, 49, 6);
    @(negedge clk);
    chk(win_ok == 0, "R2", "win_ok end<start", int'(win_ok), 0);
    strobe_src(0);
    @(negedge clk);
    chk(xfer_busy == 0, "R2", "busy after rejected arm", int'(xfer_busy), 0);
    send_word(16'hdead);
    chk_box("R2");
    set_win(1, 1, 2, 2);
    src_sel = 3'd4;
    @(negedge clk);
    chk(win_ok == 0, "R2", "win_ok source 4", int'(win_ok), 0);
    src_sel = 3'd0; pix_bytes = 3'd0;
    @(negedge clk);
    chk(win_ok == 0, "R2", "win_ok zero bytes", int'(win_ok), 0);
    pix_bytes = 3'd1;
    @(negedge clk);
    chk(win_ok == 0, "R2", "win_ok one byte", int'(win_ok), 0);

    // R10 restart discards remaining words of the old window
    @(posedge clk); #1;
    do_refresh(800, 600);
    pix_bytes = 3'd2;
    set_win(0, 0, 3, 1);
    push_exp(0, 0, 3, 1, 2, 800, 16'h4000);
    strobe_src(1);
    for (int k = 0; k < 3; k++) send_word(16'h4000 + k);
    chk(xfer_busy == 1, "R10", "busy mid-window", int'(xfer_busy), 1);
    q_addr.delete(); q_data.delete();
    set_win(10, 4, 12, 5);
    push_exp(10, 4, 12, 5, 2, 800, 16'h5000);
    strobe_src(2);
    n = nwords(10, 4, 12, 5, 2);
    for (int k = 0; k < n; k++) send_word(16'h5000 + k);
    chk(xfer_busy == 0, "R10", "busy after restarted window", int'(xfer_busy), 0);
    chk(q_addr.size() == 0, "R10", "restart words left", q_addr.size(), 0);
    merge_box(10, 4, 12, 5);
    chk_box("R10");

    // R9 enable and blank changes force the whole screen dirty
    do_refresh(800, 600);
    chk_box("R8");
    disp_en = 1;
    @(posedge clk); #1;
    bx0 = 0; bx1 = 800; by0 = 0; by1 = 600;
    chk_box("R9");
    do_refresh(800, 600);
    disp_blank = 1;
    @(posedge clk); #1;
    bx0 = 0; bx1 = 800; by0 = 0; by1 = 600;
    chk_box("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule